// File: doc/BRIEF.md
# UART Register Front End

This block sits between a simple word-addressed register bus and the byte-level halves of a minimal UART. Bytes from a receiver enter an eight-entry receive queue, and software drains that queue by reading the receive-data register. A byte that software writes to the transmit-data register goes straight out on a byte-valid output. The transmit side has no queue and always reports itself empty.

A status register shows how full the queue is, mirrors the interrupt enable, and holds three sticky error flags: overrun, framing and parity. The receiver reports framing and parity faults as one-cycle strobes. Reading status returns the flags and then clears them. The interrupt output is a one-cycle pulse, not a level. It fires when the queue takes a byte while it was empty, and when a transmit byte is written. In both cases interrupts must be enabled.

Top module: `uart_regif`

## Requirements
- R1: After reset, a status read returns 0x04, the receive queue is empty, interrupts are disabled, and `irq_o` and `tx_valid_o` are low.
- R2: The receive queue holds 8 bytes and returns them in arrival order. Status bit 0 is 1 when the queue is not empty. Status bit 1 is 1 when it holds 8 bytes.
- R3: A read of the receive-data register returns the oldest byte in bits 7:0 (upper bits zero) and removes it. A read while the queue is empty returns 0 and leaves the queue unchanged.
- R4: Status bit 2 always reads 1. Status bit 4 reads the interrupt enable, which is control bit 4. Status bit 3 and bits 31:8 read 0.
- R5: A byte arriving while the queue holds 8 bytes is dropped and sets the sticky overrun flag (status bit 5). This holds even when a receive read happens in the same cycle.
- R6: A framing strobe sets status bit 6 and a parity strobe sets status bit 7. A status read returns bits 7:5 and then clears them. An error arriving in the same cycle as the status read remains set.
- R7: A write to the transmit-data register makes `tx_valid_o` high for the next cycle only, with `tx_data_o` equal to bits 7:0 of the written word.
- R8: `irq_o` is high for exactly the cycle after a qualifying event. The events are a byte being accepted into an empty queue, and a transmit write. The interrupt enable must be set before that event's cycle; otherwise no pulse follows.
- R9: Reads of the transmit-data and control registers return 0. Writes to the receive-data register have no effect.
- R10: A control write with bit 1 set empties the receive queue and discards any byte arriving in the same cycle. The sticky flags are kept. Control bit 0 has no visible effect.
- R11: Registers are decoded from `addr_i[3:2]`: receive data 0x0, transmit data 0x4, status 0x8, control 0xC. `addr_i[1:0]` is ignored. `rdata_o` is 0 unless a read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the request |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| frame_err_i | input | 1 | Framing error strobe |
| parity_err_i | input | 1 | Parity error strobe |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Some properties are checked on every cycle: the queue never counts past its depth, an empty-queue read leaves the count alone, a flush empties the queue, and a dropped byte sets the overrun flag. Every cycle also checks that a status read with no error arriving clears the flags, that each transmit write produces the output strobe, and that no interrupt fires while the enable is clear. Other behaviour only shows up in the bench's scenarios, which the cycle-level reference model follows: byte order through the queue, what happens at the wrap-around point, the rule that a simultaneous read does not save a byte from being dropped, errors that survive a clearing read, and interrupts staying quiet for a non-empty queue or a discarded byte.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_RXV   = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_TXE   = 2;
  localparam int unsigned ST_IE    = 4;
  localparam int unsigned ST_ERR   = 5;

  localparam int unsigned CT_TXRST = 0;
  localparam int unsigned CT_RXRST = 1;
  localparam int unsigned CT_IE    = 4;

  localparam int unsigned NUM_ERR  = 3;
  localparam int unsigned ERR_OVR  = 0;
  localparam int unsigned ERR_FRM  = 1;
  localparam int unsigned ERR_PAR  = 2;
endpackage

// File: rtl/uart_regif_rxfifo.sv
module uart_regif_rxfifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          accept_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o  = (count_q == '0);
  assign full_o   = (count_q == CW'(DEPTH));
  assign accept_o = push_i & ~flush_i & ~full_o;
  // a pop in the same cycle does not make room for a push into a full queue
  assign drop_o   = push_i & ~flush_i & full_o;
  assign do_pop   = pop_i & ~flush_i & ~empty_o;
  assign data_o   = empty_o ? '0 : mem_q[rd_ptr_q];
  assign count_o  = count_q;

  always_ff @(posedge clk_i) begin
    if (accept_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (accept_o) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)   rd_ptr_q <= bump(rd_ptr_q);
      count_q <= count_q + CW'(accept_o) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/uart_regif_errs.sv
module uart_regif_errs #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    // set beats clear so an error landing on the clearing read is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned DW       = 32,
  parameter int unsigned BW       = 8,
  localparam int unsigned CW      = $clog2(RX_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_valid_i,
  input  logic [BW-1:0] rx_data_i,
  input  logic          frame_err_i,
  input  logic          parity_err_i,
  output logic          tx_valid_o,
  output logic [BW-1:0] tx_data_o,
  output logic          irq_o
);
  reg_sel_e             sel;
  logic                 rd, wr, rd_rx, rd_st, wr_tx, wr_ct;
  logic                 rx_flush;
  logic                 ie_q, irq_q, tx_valid_q;
  logic [BW-1:0]        tx_data_q, rx_head;
  logic [CW-1:0]        rx_count;
  logic                 rx_empty, rx_full, rx_accept, rx_drop;
  logic [NUM_ERR-1:0]   err_q, err_set;
  logic [DW-1:0]        status_w;
  logic                 unused_bits;

  assign sel      = reg_sel_e'(addr_i[3:2]);
  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign rd_rx    = rd & (sel == REG_RX);
  assign rd_st    = rd & (sel == REG_STAT);
  assign wr_tx    = wr & (sel == REG_TX);
  assign wr_ct    = wr & (sel == REG_CTRL);
  assign rx_flush = wr_ct & wdata_i[CT_RXRST];

  // no transmit queue: the TX reset bit has nothing to act on
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:BW], wdata_i[CT_TXRST]};

  uart_regif_rxfifo #(.DEPTH(RX_DEPTH), .DW(BW)) u_rxfifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .pop_i   (rd_rx),
    .data_o  (rx_head),
    .count_o (rx_count),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .accept_o(rx_accept),
    .drop_o  (rx_drop)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = rx_drop;
    err_set[ERR_FRM] = frame_err_i;
    err_set[ERR_PAR] = parity_err_i;
  end

  uart_regif_errs #(.N(NUM_ERR)) u_errs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (rd_st),
    .flags_o(err_q)
  );

  always_comb begin
    status_w                          = '0;
    status_w[ST_RXV]                  = ~rx_empty;
    status_w[ST_FULL]                 = rx_full;
    status_w[ST_TXE]                  = 1'b1;
    status_w[ST_IE]                   = ie_q;
    status_w[ST_ERR +: NUM_ERR]       = err_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        REG_RX:   rdata_o = DW'(rx_head);
        REG_STAT: rdata_o = status_w;
        default:  rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q       <= 1'b0;
      irq_q      <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      if (wr_ct) ie_q <= wdata_i[CT_IE];
      // enable as held before this cycle's write qualifies the event
      irq_q      <= ie_q & ((rx_accept & rx_empty) | wr_tx);
      tx_valid_q <= wr_tx;
      if (wr_tx) tx_data_q <= wdata_i[BW-1:0];
    end
  end

  assign irq_o      = irq_q;
  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk
  import uart_regif_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned AW       = 4,
  localparam int unsigned CW      = $clog2(RX_DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic               rx_valid_i,
  input logic               frame_err_i,
  input logic               parity_err_i,
  input logic               tx_valid_o,
  input logic               irq_o,
  input logic               ie_i,
  input logic [CW-1:0]      count_i,
  input logic [NUM_ERR-1:0] errs_i,
  input logic               rx_rst_i
);
  logic is_full, rd_rx, rd_st, wr_tx;
  assign is_full = (count_i == CW'(RX_DEPTH));
  assign rd_rx   = req_i & ~we_i & (addr_i[3:2] == REG_RX);
  assign rd_st   = req_i & ~we_i & (addr_i[3:2] == REG_STAT);
  assign wr_tx   = req_i & we_i & (addr_i[3:2] == REG_TX);

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(RX_DEPTH));

  a_r3_empty_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && count_i == '0 && !rx_valid_i && !rx_rst_i) |=> (count_i == '0));

  a_r5_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && is_full && !rx_rst_i) |=> errs_i[ERR_OVR]);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && !frame_err_i && !parity_err_i && !(rx_valid_i && is_full && !rx_rst_i))
      |=> (errs_i == '0));

  a_r7_tx_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> tx_valid_o);

  a_r8_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ie_i));

  a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_i |=> (count_i == '0));
endmodule

bind uart_regif uart_regif_chk #(.RX_DEPTH(RX_DEPTH), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rx_valid_i  (rx_valid_i),
  .frame_err_i (frame_err_i),
  .parity_err_i(parity_err_i),
  .tx_valid_o  (tx_valid_o),
  .irq_o       (irq_o),
  .ie_i        (ie_q),
  .count_i     (rx_count),
  .errs_i      (err_q),
  .rx_rst_i    (rx_flush)
);

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        frame_err_i = 1'b0, parity_err_i = 1'b0;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  byte unsigned q[$];
  bit m_ie, m_ovr, m_frm, m_par, m_txv, m_irq;
  byte unsigned m_txd;

  always #4 clk_i = ~clk_i;

  uart_regif dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .frame_err_i(frame_err_i), .parity_err_i(parity_err_i), .tx_valid_o(tx_valid_o),
    .tx_data_o(tx_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    return {24'd0, m_par, m_frm, m_ovr, m_ie, 1'b0, 1'b1,
            q.size() == DEPTH, q.size() != 0};
  endfunction

  function automatic logic [31:0] m_rdata(input bit rq, input bit w, input logic [3:0] a);
    if (!rq || w) return 32'd0;
    case (a[3:2])
      2'd0: return (q.size() != 0) ? {24'd0, q[0]} : 32'd0;
      2'd2: return m_status();
      default: return 32'd0;
    endcase
  endfunction

  // one bus cycle: drive at negedge, check read data, model the edge, check outputs
  task automatic cyc(input string tag, input bit rq, input bit w, input logic [3:0] a,
                     input logic [31:0] wd, input bit rxv, input logic [7:0] rxd,
                     input bit fe, input bit pe);
    bit flush, was_empty, was_full, n_irq;
    req_i = rq; we_i = w; addr_i = a; wdata_i = wd;
    rx_valid_i = rxv; rx_data_i = rxd; frame_err_i = fe; parity_err_i = pe;
    #1;
    if (rq && !w) chk(tag, "rdata", rdata_o, m_rdata(rq, w, a));
    @(posedge clk_i);
    flush = rq && w && a[3:2] == 2'd3 && wd[1];
    was_empty = (q.size() == 0);
    was_full  = (q.size() == DEPTH);
    n_irq = 0;
    if (flush) q.delete();
    else begin
      if (rq && !w && a[3:2] == 2'd0 && !was_empty) void'(q.pop_front());
      if (rxv) begin
        if (was_full) m_ovr = 1;
        else begin
          q.push_back(rxd);
          if (was_empty && m_ie) n_irq = 1;
        end
      end
    end
    if (rq && !w && a[3:2] == 2'd2) begin
      m_ovr = (rxv && was_full && !flush); m_frm = 0; m_par = 0;
    end
    if (fe) m_frm = 1;
    if (pe) m_par = 1;
    m_txv = rq && w && a[3:2] == 2'd1;
    if (m_txv) begin
      m_txd = wd[7:0];
      if (m_ie) n_irq = 1;
    end
    if (rq && w && a[3:2] == 2'd3) m_ie = wd[4];
    m_irq = n_irq;
    @(negedge clk_i);
    chk(tag, "tx_valid", {31'd0, tx_valid_o}, {31'd0, m_txv});
    if (m_txv) chk(tag, "tx_data", {24'd0, tx_data_o}, {24'd0, m_txd});
    chk(tag, "irq", {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 4'h0, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic rd(input string tag, input logic [3:0] a);
    cyc(tag, 1, 0, a, 0, 0, 8'h00, 0, 0);
  endtask
  task automatic wrr(input string tag, input logic [3:0] a, input logic [31:0] d);
    cyc(tag, 1, 1, a, d, 0, 8'h00, 0, 0);
  endtask
  task automatic rx(input string tag, input logic [7:0] d);
    cyc(tag, 0, 0, 4'h0, 0, 1, d, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", "irq in reset", {31'd0, irq_o}, 32'd0);
    chk("R1", "tx_valid in reset", {31'd0, tx_valid_o}, 32'd0);
    rst_ni = 1'b1;
    rd("R1", 4'h8);
    chk("R1", "status literal", m_status(), 32'h4);

    wrr("R4", 4'hC, 32'h10);
    rd("R4", 4'h8);
    rd("R11", 4'hB);                       // low address bits ignored
    rx("R8", 8'hA1);                       // empty -> one entry: pulse
    rx("R8", 8'hB2);                       // non-empty: no pulse
    rd("R3", 4'h0);
    rd("R3", 4'h1);
    rd("R3", 4'h0);                        // empty read returns 0
    rd("R3", 4'h8);

    for (int i = 0; i < DEPTH; i++) rx("R2", 8'h10 + 8'(i));
    rd("R2", 4'h8);                        // full flag
    rx("R5", 8'hEE);                       // dropped, overrun
    cyc("R5", 1, 0, 4'h0, 0, 1, 8'hEF, 0, 0); // read + arrival while full: still dropped
    rd("R5", 4'h8);
    rd("R6", 4'h8);                        // cleared
    for (int i = 0; i < DEPTH; i++) rd("R2", 4'h0);
    rd("R2", 4'h8);

    cyc("R6", 0, 0, 4'h0, 0, 0, 8'h00, 1, 0);
    cyc("R6", 0, 0, 4'h0, 0, 0, 8'h00, 0, 1);
    rd("R6", 4'h8);
    cyc("R6", 1, 0, 4'h8, 0, 0, 8'h00, 1, 0); // strobe on the clearing read survives
    rd("R6", 4'h8);
    rd("R6", 4'h8);

    wrr("R7", 4'h4, 32'hFFFF_FF5A);
    idle("R7");
    wrr("R8", 4'hC, 32'h0);
    wrr("R8", 4'h4, 32'h33);              // IE off: no pulse
    rx("R8", 8'h44);
    wrr("R8", 4'hC, 32'h10);
    wrr("R8", 4'h4, 32'h34);
    wrr("R7", 4'h4, 32'h35);              // back-to-back strobes

    rd("R9", 4'h4);
    rd("R9", 4'hC);
    wrr("R9", 4'h0, 32'h99);
    rd("R9", 4'h8);

    rx("R10", 8'h55);
    cyc("R10", 0, 0, 4'h0, 0, 0, 8'h00, 1, 0);
    cyc("R10", 1, 1, 4'hC, 32'h12, 1, 8'h66, 0, 0); // flush + arrival: discarded
    rd("R10", 4'h8);
    rd("R10", 4'h0);
    rx("R10", 8'h77);
    wrr("R10", 4'hC, 32'h11);             // TX reset bit: no effect
    rd("R10", 4'h8);
    rd("R10", 4'h0);

    for (int i = 0; i < 400; i++) begin
      bit rq, w, rxv, fe, pe;
      logic [3:0] a;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      rq  = lfsr[31];
      w   = lfsr[30] & lfsr[29];
      a   = {lfsr[28:27], lfsr[26:25]};
      rxv = lfsr[24] | lfsr[23];
      fe  = (lfsr[22:19] == 4'h0);
      pe  = (lfsr[18:15] == 4'h0);
      if (w && a[3:2] == 2'd3 && lfsr[14]) a = 4'h4;
      cyc("R2", rq, w, a, {16'd0, lfsr[15:0] | 16'h0010}, rxv, lfsr[7:0], fe, pe);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule